// File: doc/BRIEF.md
# Sixteen-Bit Compare-Match Timer Channel

This block is one up-counting timer channel with a 16-bit counter, read and written over a small word-wide register bus. The counter advances from a free-running internal prescaler or from one of four external count pins. The prescaler can divide by 1, 2, 4 or 8. Its counting edge can be phase 0, delayed by half a divided period, or both edges, which doubles the rate.

Four compare registers are watched against the counter. When the counter lands on a compare value, the matching status flag is set, but only if that compare's interrupt enable is on. The same applies when the counter wraps from 0xFFFF to 0 with the overflow enable on. A control field can also make the counter clear itself: either after a chosen compare value or on an external synchronous clear pin.

Software clears a flag by writing 0 to its status bit. An interrupt line is driven for every flag that is set and enabled. The channel only advances while its external `run` input is high.

Top module: `cmt16_channel`

## Requirements
- R1: After reset the control register reads 0x00, the counter 0x0000, every compare register 0xFFFF, the enable register 0x40 and the status register 0xC0.
- R2: Register addresses are 0 control, 1 interrupt enable, 2 status, 3 counter, and 4 to 7 compare A to D. Byte registers read zero-extended.
- R3: A 4-bit prescaler counts every clock from reset. With control bits 2:0 = d in 0..3 and edge bits 4:3 = 00, the counter advances on the edges where the prescaler value mod 2^d is 0.
- R4: Edge bits 4:3 = 01 with d > 0 advance where the prescaler value mod 2^d equals 2^(d-1). Edge bits 1x with d > 0 advance where the prescaler value mod 2^(d-1) is 0.
- R5: Control bits 2:0 = 4..7 count rising edges of external count pin 0..3. Each pin passes through two synchronizing flip-flops, and the other pins are ignored.
- R6: While `run` is low and no counter write occurs, the counter holds its value.
- R7: When an advance brings the counter equal to compare register i (i = 0..3) and enable bit i is set, status bit i is set. When enable bit i is clear, status bit i stays 0.
- R8: An advance from 0xFFFF with enable bit 4 set sets status bit 4.
- R9: With control bits 6:5 = 01 or 10, an advance from a counter equal to compare A or B respectively loads 0 instead of incrementing. Control bit 7 set redirects these to compare C or D.
- R10: With control bits 6:5 = 11, `ext_clr` high while `run` is high zeroes the counter on the next edge. With other settings `ext_clr` has no effect.
- R11: Writing 0 to a status bit clears it and writing 1 leaves it unchanged. A flag set in the same cycle as a clearing write stays set. Status bits 7:6 read as 1 and bit 5 as 0.
- R12: `irq[i]` is high exactly when status bit i and enable bit i are both set (i = 0..4).
- R13: Enable register bit 6 always reads 1. The other seven bits read back as written.
- R14: A counter write takes priority over an advance or clear in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Channel count enable |
| addr | input | 3 | Register address |
| wr_en | input | 1 | Register write strobe |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for `addr` (combinational) |
| ext_cnt | input | 4 | External count pins |
| ext_clr | input | 1 | External synchronous clear |
| irq | output | 5 | Interrupt requests: compare A-D, overflow |

## Verification
A compare flag can be set by a counter advance in the same cycle that software writes 0 to the status register. The bench provokes this by parking the counter one below compare A with `run` low. It then raises `run` for exactly the edge that carries the clearing status write. The flag must read back as set, since the new match outranks the clear. A second collision drives a counter write during a running count: the counter must hold the written value rather than that value plus one.

// File: rtl/cmt16_channel.sv
module cmt16_channel #(
  parameter int NCMP = 4,
  parameter int CW   = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [2:0]    addr,
  input  logic          wr_en,
  input  logic [CW-1:0] wdata,
  output logic [CW-1:0] rdata,
  input  logic [3:0]    ext_cnt,
  input  logic          ext_clr,
  output logic [4:0]    irq
);
  localparam logic [2:0] A_CTRL = 3'd0, A_IEN = 3'd1, A_STAT = 3'd2, A_CNT = 3'd3;
  localparam bit FOUR_CMP = (NCMP > 2);

  logic [7:0]    ctrl;
  logic [7:0]    ien_q;
  logic [4:0]    flg;
  logic [CW-1:0] cnt;
  logic [3:0]    pre;
  logic [3:0]    s1, s2, s3;
  logic [CW-1:0] cmp [4];

  logic [1:0] dsh;
  logic [3:0] ph;
  always_comb begin
    dsh = ctrl[1:0];
    ph  = 4'd0;
    if (ctrl[1:0] != 2'd0) begin
      case (ctrl[4:3])
        2'b01:   ph  = 4'd1 << (ctrl[1:0] - 2'd1);
        2'b10,
        2'b11:   dsh = ctrl[1:0] - 2'd1;
        default: ;
      endcase
    end
  end

  wire [3:0] pmask = (4'd1 << dsh) - 4'd1;
  wire       itick = (((pre + ph) & pmask) == 4'd0);
  wire [3:0] erise = s2 & ~s3;
  wire       etick = erise[ctrl[1:0]];
  wire       tick  = run & (ctrl[2] ? etick : itick);

  wire       clr_cmp = ctrl[6] ^ ctrl[5];
  wire [1:0] csel    = {FOUR_CMP & ctrl[7], ctrl[6]};
  wire       hit_clr = tick & clr_cmp & (cnt == cmp[csel]);
  wire       sclr    = run & (ctrl[6:5] == 2'b11) & ext_clr;
  wire       cnt_wr  = wr_en & (addr == A_CNT);
  wire       adv     = tick & ~cnt_wr & ~sclr;
  wire [CW-1:0] cnt_nx = hit_clr ? '0 : cnt + 1'b1;

  logic [4:0] fset;
  always_comb begin
    for (int i = 0; i < 4; i++)
      fset[i] = adv & ien_q[i] & (i < NCMP) & (cnt_nx == cmp[i]);
    fset[4] = adv & ien_q[4] & (&cnt);
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pre <= '0;
      s1  <= '0;
      s2  <= '0;
      s3  <= '0;
    end else begin
      pre <= pre + 4'd1;
      s1  <= ext_cnt;
      s2  <= s1;
      s3  <= s2;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                        ctrl <= '0;
    else if (wr_en && addr == A_CTRL)  ctrl <= wdata[7:0];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                        ien_q <= '0;
    else if (wr_en && addr == A_IEN)   ien_q <= wdata[7:0];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                        flg <= '0;
    else if (wr_en && addr == A_STAT)  flg <= (flg & wdata[4:0]) | fset;
    else                               flg <= flg | fset;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       cnt <= '0;
    else if (cnt_wr)  cnt <= wdata;
    else if (sclr)    cnt <= '0;
    else if (tick)    cnt <= cnt_nx;

  for (genvar g = 0; g < 4; g++) begin : g_cmp
    if (g < NCMP) begin : g_reg
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n)                            cmp[g] <= '1;
        else if (wr_en && addr == 3'(4 + g))   cmp[g] <= wdata;
    end else begin : g_none
      assign cmp[g] = '1;
    end
  end

  always_comb
    case (addr)
      A_CTRL:  rdata = {{(CW-8){1'b0}}, ctrl};
      A_IEN:   rdata = {{(CW-8){1'b0}}, ien_q[7], 1'b1, ien_q[5:0]};
      A_STAT:  rdata = {{(CW-8){1'b0}}, 3'b110, flg};
      A_CNT:   rdata = cnt;
      default: rdata = cmp[addr[1:0]];
    endcase

  assign irq = flg & ien_q[4:0];

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !cnt_wr) |=> (cnt == $past(cnt))); // R6
  AST_AUTO_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && clr_cmp && cnt == cmp[csel] && !cnt_wr && !sclr) |=> (cnt == '0)); // R9
  AST_SYNC_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (sclr && !cnt_wr) |=> (cnt == '0)); // R10
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && addr == A_STAT) |=> ((flg & $past(flg)) == $past(flg))); // R11
  AST_OVF_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (run && tick && (&cnt) && ien_q[4] && !cnt_wr && !sclr) |=> flg[4]); // R8
  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr |=> (cnt == $past(wdata))); // R14
endmodule

// File: tb/cmt16_channel_tb.sv
`timescale 1ns/1ps
module cmt16_channel_tb;
  logic clk = 0, rst_n = 0, run = 0, wr_en = 0, ext_clr = 0;
  logic [2:0]  addr = 0;
  logic [15:0] wdata = 0;
  logic [3:0]  ext_cnt = 0;
  wire  [15:0] rdata;
  wire  [4:0]  irq;

  cmt16_channel u_dut (.clk(clk), .rst_n(rst_n), .run(run), .addr(addr), .wr_en(wr_en),
    .wdata(wdata), .rdata(rdata), .ext_cnt(ext_cnt), .ext_clr(ext_clr), .irq(irq));

  always #2 clk = ~clk;

  int nrun = 0, nfail = 0;
  logic [15:0] exp_q[$];
  string       tag_q[$];
  logic        rd_req = 0;

  int ecnt;
  always @(posedge clk or negedge rst_n)
    if (!rst_n) ecnt <= 0; else ecnt <= ecnt + 1;

  logic [15:0] prv, maxc;
  bit pv = 0;
  int lastp, nchg;
  always @(negedge clk) begin
    if (addr == 3'd3 && !wr_en) begin
      if (pv && rdata != prv) begin lastp = ecnt - 1; nchg++; end
      if (rdata > maxc) maxc = rdata;
      prv = rdata; pv = 1;
    end else pv = 0;
  end

  always @(negedge clk)
    if (rd_req) begin
      logic [15:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      nrun++;
      if (rdata !== e) begin
        nfail++;
        $display("FAIL %s: read got %h expected %h", t, rdata, e);
      end
    end

  task automatic chk(input string t, input int act, input int exp);
    nrun++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: got %0d expected %0d", t, act, exp);
    end
  endtask

  task automatic wr(input [2:0] a, input [15:0] d);
    @(posedge clk); #1; addr = a; wdata = d; wr_en = 1;
    @(posedge clk); #1; wr_en = 0;
  endtask

  task automatic rd(input [2:0] a, input [15:0] e, input string t);
    @(posedge clk); #1; addr = a;
    exp_q.push_back(e); tag_q.push_back(t); rd_req = 1;
    @(negedge clk); #1; rd_req = 0;
  endtask

  task automatic run_for(input int n);
    @(posedge clk); #1; run = 1;
    repeat (n) @(posedge clk);
    #1; run = 0;
  endtask

  task automatic presc(input [7:0] c, input int md, input int res, input int nt, input string t);
    run = 0;
    wr(3, 0); wr(0, c);
    @(posedge clk); #1; addr = 3;
    @(posedge clk); #1; run = 1; nchg = 0;
    repeat (32) @(posedge clk);
    #1; run = 0;
    @(negedge clk); #1;
    chk({t, " edge residue"}, lastp % md, res);
    chk({t, " advance count"}, nchg, nt);
  endtask

  task automatic pulse(input int pin, input int n);
    for (int k = 0; k < n; k++) begin
      @(posedge clk); #1; ext_cnt[pin] = 1;
      repeat (3) @(posedge clk);
      #1; ext_cnt[pin] = 0;
      repeat (3) @(posedge clk);
    end
  endtask

  initial begin
    #800000;
    nfail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", nrun, nfail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1; rst_n = 1;
    // R1 R2 reset values via map
    rd(0, 16'h0000, "R1 ctrl");
    rd(1, 16'h0040, "R1 ien");
    rd(2, 16'h00C0, "R1 stat");
    rd(3, 16'h0000, "R1 cnt");
    for (int i = 4; i < 8; i++) rd(3'(i), 16'hFFFF, "R1 R2 cmp");

    // R13
    wr(1, 16'h0000); rd(1, 16'h0040, "R13 bit6 set");
    wr(1, 16'h00BF); rd(1, 16'h00FF, "R13 readback");
    wr(1, 16'h0000);

    // R3 R4 prescaler
    presc(8'h00, 1, 0, 32, "R3 div1");
    presc(8'h02, 4, 0, 8,  "R3 div4");
    presc(8'h03, 8, 0, 4,  "R3 div8");
    presc(8'h0B, 8, 4, 4,  "R4 div8 half");
    presc(8'h13, 4, 0, 8,  "R4 div8 both");
    presc(8'h09, 2, 1, 16, "R4 div2 half");

    // R6 hold
    wr(0, 0); wr(3, 0);
    run_for(10);
    rd(3, 16'd10, "R6 counted");
    repeat (5) @(posedge clk);
    rd(3, 16'd10, "R6 held");

    // R14 write beats advance
    @(posedge clk); #1; run = 1;
    wr(3, 16'h1234);
    run = 0;
    rd(3, 16'h1234, "R14 write priority");

    // R7 disabled compare
    wr(4, 16'h0010); wr(1, 0); wr(2, 0); wr(3, 0);
    run_for(20);
    rd(2, 16'h00C0, "R7 disabled no flag");
    chk("R12 no irq", irq, 0);
    // R7 enabled compare
    wr(1, 16'h0001); wr(3, 0);
    run_for(20);
    rd(2, 16'h00C1, "R7 flag A");
    chk("R12 irq A", irq, 1);
    // R11 write 1 no effect, write 0 clears
    wr(2, 16'h00FF); rd(2, 16'h00C1, "R11 write one");
    wr(2, 16'h00FE); rd(2, 16'h00C0, "R11 write zero");

    // R11 collision: match and clear in same edge
    wr(3, 16'h000F);
    @(posedge clk); #1; addr = 2; wdata = 0; wr_en = 1; run = 1;
    @(posedge clk); #1; wr_en = 0; run = 0;
    rd(2, 16'h00C1, "R11 set beats clear");
    rd(3, 16'h0010, "R11 counter advanced");
    wr(2, 0);

    // R9 auto-clear on B
    wr(5, 16'd5); wr(1, 16'h0002); wr(3, 0); wr(0, 16'h0040);
    @(posedge clk); #1; addr = 3; maxc = 0;
    run_for(30);
    @(negedge clk); #1;
    chk("R9 clear B max", maxc, 5);
    rd(3, 16'd0, "R9 clear B period");
    rd(2, 16'h00C2, "R9 flag B");
    chk("R12 irq B", irq, 2);
    wr(2, 0);
    // R9 redirect to C
    wr(6, 16'd3); wr(1, 16'h0004); wr(3, 0); wr(0, 16'h00A0);
    @(posedge clk); #1; addr = 3; maxc = 0;
    run_for(20);
    @(negedge clk); #1;
    chk("R9 clear C max", maxc, 3);
    rd(3, 16'd0, "R9 clear C period");
    rd(2, 16'h00C4, "R9 flag C");
    wr(2, 0);
    // R9 redirect to D
    wr(7, 16'd2); wr(1, 0); wr(3, 0); wr(0, 16'h00C0);
    run_for(10);
    rd(3, 16'd1, "R9 clear D");

    // R8 overflow
    wr(0, 0); wr(1, 16'h0010); wr(2, 0); wr(3, 16'hFFFD);
    run_for(5);
    rd(3, 16'h0002, "R8 wrapped");
    rd(2, 16'h00D0, "R8 flag");
    chk("R12 irq ovf", irq, 16);
    wr(2, 0); wr(1, 0);

    // R10 sync clear
    wr(0, 16'h0060); wr(3, 16'h0100);
    @(posedge clk); #1; ext_clr = 1; run = 1;
    @(posedge clk); #1; ext_clr = 0; run = 0;
    rd(3, 16'h0000, "R10 cleared");
    wr(0, 16'h0000); wr(3, 16'h0100);
    @(posedge clk); #1; ext_clr = 1; run = 1;
    @(posedge clk); #1; ext_clr = 0; run = 0;
    rd(3, 16'h0101, "R10 ignored");

    // R5 external count
    wr(0, 16'h0004); wr(3, 0);
    @(posedge clk); #1; run = 1;
    pulse(0, 3); pulse(1, 2);
    repeat (6) @(posedge clk);
    #1; run = 0;
    rd(3, 16'd3, "R5 pin0 only");
    wr(0, 16'h0005); wr(3, 0);
    @(posedge clk); #1; run = 1;
    pulse(0, 3); pulse(1, 2);
    repeat (6) @(posedge clk);
    #1; run = 0;
    rd(3, 16'd2, "R5 pin1 only");

    repeat (4) @(posedge clk);
    $display("[TB] %0d tests run, %0d failed", nrun, nfail);
    $finish;
  end
endmodule